// File: doc/BRIEF.md
# Bus Search Branch Step

This block carries out one decision step of the ROM search on a single-wire open-drain bus. A host pulses a start request together with the branch direction it would like to follow. The block then runs three single-bit transfers through an attached bit-level bus engine:

- a read of the ID bit;
- a read of the complemented ID bit;
- a write of the chosen branch direction.

The block resolves the branch from the two bits it read and reports a packed 3-bit code. The host repeats the step once for each bit position. Keeping track of discrepancies across the whole ROM and checking the CRC is the host's job.

Every slave on the bus drives its own bit onto the wire, and the wire reads as the logical AND of them. The two reads therefore tell three cases apart:

- Both reads give 1: no slave is taking part. The block stops without writing anything.
- Both reads give 0: the slaves disagree at this position. The host's preference decides the branch.
- The reads differ: every slave agrees. The branch is forced to the ID bit.

A watchdog limits each sub-transfer to a set number of cycles. If a transfer runs past that limit, the step is aborted and reported as an error.

The controller steps through five states:

| State | Action |
|---|---|
| IDLE | Waits for a start request. |
| RD_ID | Reads the ID bit. |
| RD_CMP | Reads the complement bit. |
| WR_DIR | Writes the branch direction. |
| FINISH | Lasts one cycle and flags completion. |

Its transitions are:

| From | To | Condition |
|---|---|---|
| IDLE | RD_ID | start request |
| RD_ID | RD_CMP | acknowledge |
| RD_CMP | WR_DIR | acknowledge when the two bits are not both high |
| RD_CMP | FINISH | acknowledge when both bits are high |
| WR_DIR | FINISH | acknowledge |
| RD_ID, RD_CMP or WR_DIR | FINISH | watchdog expiry |
| FINISH | IDLE | unconditional |

Top module: `owire_triplet_step`

## Requirements
- R1: A step performs its first transfer as a read (bit_wr_o=0), which returns the ID bit, and its second transfer as a read (bit_wr_o=0), which returns the complement bit, in that order.
- R2: When both reads return 1, result_o is 3'b011, error_o is 0, and no write transfer is issued.
- R3: When both reads return 0, the direction taken equals the preferred direction sampled with start. result_o is 3'b100 for direction 1 and 3'b000 for direction 0.
- R4: When exactly one read returns 1, the direction is forced to the ID bit value. result_o is 3'b101 when the ID bit is 1 and 3'b010 when it is 0.
- R5: The result code carries the ID bit in bit 0, the complement bit in bit 1 and the direction taken in bit 2.
- R6: Unless the step stops early, the third transfer is a write (bit_wr_o=1) whose bit_wdata_o equals the direction taken. The step then finishes with error_o=0.
- R7: If a sub-transfer is not acknowledged within TIMEOUT_CYC cycles of its request, the step aborts without further transfers, result_o is 3'b011 and error_o is 1.
- R8: busy_o rises in the cycle after a start is accepted and stays high until done_o. done_o is a single-cycle pulse in the last busy cycle. result_o and error_o are valid while done_o is high and are held until the next step finishes.
- R9: A start request that arrives while busy_o is high is ignored. It neither changes the running step nor launches another step. A change on pref_dir_i during a step has no effect.
- R10: bit_req_o, bit_wr_o and bit_wdata_o hold steady from the request until the cycle in which bit_ack_i is high. bit_rdata_i is sampled in that cycle.
- R11: After reset, busy_o, done_o, bit_req_o, error_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run one search step |
| pref_dir_i | input | 1 | Direction preferred by the host, sampled with start |
| busy_o | output | 1 | High while a step is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | {direction, complement bit, ID bit}; 3'b011 on absence or abort |
| error_o | output | 1 | The last step aborted on a transfer timeout |
| bit_req_o | output | 1 | Transfer request to the bit engine |
| bit_wr_o | output | 1 | 1 = write transfer, 0 = read transfer |
| bit_wdata_o | output | 1 | Bit to write |
| bit_ack_i | input | 1 | Bit engine completes the transfer (one cycle) |
| bit_rdata_i | input | 1 | Bit read, valid with bit_ack_i |

## Verification
A controller that sits in the wrong state shows at the bit-engine port on its very next transfer. Skipping or reordering a state turns up as a write among the first two transfers, as a third transfer after an all-high pair, or as a missing write. A wrongly captured ID bit or complement bit, or a wrongly captured preferred direction, corrupts both the written bit and the packed code. Both show up in the done cycle of the same step. A watchdog that counts wrongly shows up as an abort on a transfer that was slow but legal, or as a step that hangs well past the limit.

// File: rtl/owire_triplet_pkg.sv
package owire_triplet_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ID,
        ST_RD_CMP,
        ST_WR_DIR,
        ST_FINISH
    } step_state_t;

    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] CODE_NONE = 3'b011;

endpackage

// File: rtl/owire_xfer_wdog.sv
module owire_xfer_wdog #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic ack_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active_i || ack_i) begin
            cnt_q <= '0;
        end else if (!expire_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = active_i && !ack_i && (cnt_q == CW'(LIMIT - 1));

    // R7: the counter never runs past the last permitted cycle
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/owire_branch_pick.sv
module owire_branch_pick (
    input  logic       id_i,
    input  logic       cmp_i,
    input  logic       pref_i,
    output logic       absent_o,
    output logic       dir_o,
    output logic [2:0] code_o
);
    always_comb begin
        absent_o = id_i & cmp_i;
        if (id_i ^ cmp_i) begin
            dir_o = id_i;
        end else if (absent_o) begin
            dir_o = 1'b0;
        end else begin
            dir_o = pref_i;
        end
        code_o = {dir_o, cmp_i, id_i};
    end

    // R3, R4: a direction that differs from the preference is only taken when the bits disagree
    always_comb begin
        if (!absent_o && (id_i == cmp_i)) begin
            a_pref_taken_r3: assert (dir_o == pref_i);
        end
    end

endmodule

// File: rtl/owire_triplet_step.sv
module owire_triplet_step
    import owire_triplet_pkg::*;
#(
    parameter int TIMEOUT_CYC = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       pref_dir_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [2:0] result_o,
    output logic       error_o,
    output logic       bit_req_o,
    output logic       bit_wr_o,
    output logic       bit_wdata_o,
    input  logic       bit_ack_i,
    input  logic       bit_rdata_i
);
    step_state_t state_q, state_d;
    logic        id_q, cmp_q, pref_q, err_q;
    logic [2:0]  result_q;
    logic        expire;
    logic        cmp_sel, absent, dir;
    logic [2:0]  code;

    owire_xfer_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (bit_req_o),
        .ack_i    (bit_ack_i),
        .expire_o (expire)
    );

    assign cmp_sel = (state_q == ST_RD_CMP) ? bit_rdata_i : cmp_q;

    owire_branch_pick u_pick (
        .id_i     (id_q),
        .cmp_i    (cmp_sel),
        .pref_i   (pref_q),
        .absent_o (absent),
        .dir_o    (dir),
        .code_o   (code)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_RD_ID;
            ST_RD_ID:  if (bit_ack_i) state_d = ST_RD_CMP;
                       else if (expire) state_d = ST_FINISH;
            ST_RD_CMP: if (bit_ack_i) state_d = absent ? ST_FINISH : ST_WR_DIR;
                       else if (expire) state_d = ST_FINISH;
            ST_WR_DIR: if (bit_ack_i || expire) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // state and captured bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            id_q     <= 1'b0;
            cmp_q    <= 1'b0;
            pref_q   <= 1'b0;
            err_q    <= 1'b0;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) pref_q <= pref_dir_i;
                end
                ST_RD_ID: begin
                    if (bit_ack_i) begin
                        id_q <= bit_rdata_i;
                    end else if (expire) begin
                        result_q <= CODE_NONE;
                        err_q    <= 1'b1;
                    end
                end
                ST_RD_CMP: begin
                    if (bit_ack_i) begin
                        cmp_q <= bit_rdata_i;
                        if (absent) begin
                            result_q <= code;
                            err_q    <= 1'b0;
                        end
                    end else if (expire) begin
                        result_q <= CODE_NONE;
                        err_q    <= 1'b1;
                    end
                end
                ST_WR_DIR: begin
                    if (bit_ack_i) begin
                        result_q <= code;
                        err_q    <= 1'b0;
                    end else if (expire) begin
                        result_q <= CODE_NONE;
                        err_q    <= 1'b1;
                    end
                end
                ST_FINISH: ;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_FINISH);
        bit_req_o   = (state_q == ST_RD_ID) || (state_q == ST_RD_CMP) ||
                      (state_q == ST_WR_DIR);
        bit_wr_o    = (state_q == ST_WR_DIR);
        bit_wdata_o = (state_q == ST_WR_DIR) && dir;
        result_o    = result_q;
        error_o     = err_q;
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req_o && !bit_ack_i && !expire) |=>
            (bit_req_o && $stable(bit_wr_o) && $stable(bit_wdata_o)));

    p_err_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && error_o) |-> (result_o == CODE_NONE));

    p_no_write_absent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_wr_o |-> !(id_q && cmp_q));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(pref_q));

endmodule

// File: tb/owire_triplet_step_tb.sv
module owire_triplet_step_tb;
    localparam int LIMIT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic pref_dir_i = 1'b0;
    logic busy_o, done_o, error_o;
    logic [2:0] result_o;
    logic bit_req_o, bit_wr_o, bit_wdata_o;
    logic bit_ack_i = 1'b0;
    logic bit_rdata_i = 1'b0;

    always #10 clk = ~clk;

    owire_triplet_step #(.TIMEOUT_CYC(LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pref_dir_i(pref_dir_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .error_o(error_o),
        .bit_req_o(bit_req_o), .bit_wr_o(bit_wr_o), .bit_wdata_o(bit_wdata_o),
        .bit_ack_i(bit_ack_i), .bit_rdata_i(bit_rdata_i)
    );

    // slave model: up to four slaves, wired-AND bus
    logic [3:0] sl_present = 4'h0;
    logic [3:0] sl_bit = 4'h0;
    int log_n = 0;
    int step_base = 0;
    int ack_limit = 1000000;
    int dly = 0;
    int dly_target = 0;
    logic log_wr [0:255];
    logic log_wd [0:255];

    function automatic logic bus_id(input logic [3:0] p, input logic [3:0] b);
        return &(~p | b);
    endfunction
    function automatic logic bus_cmp(input logic [3:0] p, input logic [3:0] b);
        return &(~p | ~b);
    endfunction

    always @(posedge clk) begin
        if (bit_ack_i) begin
            bit_ack_i <= 1'b0;
            dly <= 0;
        end else if (!bit_req_o || log_n >= ack_limit) begin
            dly <= 0;
        end else if (dly >= dly_target) begin
            bit_ack_i <= 1'b1;
            bit_rdata_i <= (log_n - step_base == 0) ? bus_id(sl_present, sl_bit)
                                                    : bus_cmp(sl_present, sl_bit);
            log_wr[log_n % 256] <= bit_wr_o;
            log_wd[log_n % 256] <= bit_wdata_o;
            log_n <= log_n + 1;
            dly <= 0;
            dly_target <= $urandom % 4;
        end else begin
            dly <= dly + 1;
        end
    end

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_code(input logic id, input logic cmp, input logic pref);
        if (id && cmp) return 3'b011;
        if (!id && !cmp) return pref ? 3'b100 : 3'b000;
        return id ? 3'b101 : 3'b010;
    endfunction

    // budget: number of acks the responder grants in this step (3 = all)
    task automatic do_step(input logic pref, input int budget, input bit inject);
        logic id, cmp;
        logic [2:0] ecode;
        int nx, wait_cnt, after_n;
        bit exp_err;
        @(negedge clk);
        step_base = log_n;
        ack_limit = log_n + budget;
        id = bus_id(sl_present, sl_bit);
        cmp = bus_cmp(sl_present, sl_bit);
        start_i = 1'b1;
        pref_dir_i = pref;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
        if (inject) begin
            @(negedge clk);
            pref_dir_i = ~pref;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_cnt = 0;
        while (!done_o && wait_cnt < 400) begin
            @(negedge clk);
            wait_cnt++;
        end
        chk(done_o == 1'b1, "R8 done seen", done_o, 1);
        nx = log_n - step_base;
        exp_err = (budget < 2) || (budget == 2 && !(id && cmp));
        if (exp_err) begin
            chk(result_o == 3'b011, "R7 abort code", result_o, 3'b011);
            chk(error_o == 1'b1, "R7 error flag", error_o, 1);
            chk(nx == budget, "R7 no further transfers", nx, budget);
        end else begin
            ecode = exp_code(id, cmp, pref);
            chk(result_o == ecode, (id == cmp) ? (id ? "R2 code" : "R3 code") : "R4 code",
                result_o, ecode);
            chk(result_o[1:0] == {cmp, id}, "R5 code bits", result_o[1:0], {cmp, id});
            chk(error_o == 1'b0, "R6 no error", error_o, 0);
            chk(log_wr[step_base % 256] == 1'b0 && log_wr[(step_base + 1) % 256] == 1'b0,
                "R1 reads first", log_wr[(step_base + 1) % 256], 0);
            if (id && cmp) begin
                chk(nx == 2, "R2 no write", nx, 2);
            end else begin
                chk(nx == 3, "R6 write issued", nx, 3);
                chk(log_wr[(step_base + 2) % 256] == 1'b1, "R6 write kind",
                    log_wr[(step_base + 2) % 256], 1);
                chk(log_wd[(step_base + 2) % 256] == ecode[2], "R6 write bit",
                    log_wd[(step_base + 2) % 256], ecode[2]);
            end
        end
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R8 done one cycle", {busy_o, done_o}, 0);
        if (inject) begin
            after_n = log_n;
            repeat (4) @(negedge clk);
            chk(busy_o == 1'b0 && log_n == after_n, "R9 start while busy ignored",
                log_n - after_n, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (2) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && bit_req_o == 0 && error_o == 0 &&
            result_o == 3'b000, "R11 reset state",
            {busy_o, done_o, bit_req_o, error_o, result_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: no slave present
        sl_present = 4'h0; sl_bit = 4'h0;
        do_step(1'b1, 3, 1'b0);
        // all present slaves have 1
        sl_present = 4'hF; sl_bit = 4'hF;
        do_step(1'b0, 3, 1'b0);
        // all have 0
        sl_bit = 4'h0;
        do_step(1'b1, 3, 1'b0);
        // discrepancy, both preferences
        sl_bit = 4'h5;
        do_step(1'b0, 3, 1'b0);
        do_step(1'b1, 3, 1'b0);
        // start while busy, pref flipped mid-step
        do_step(1'b1, 3, 1'b1);
        sl_present = 4'h3; sl_bit = 4'h3;
        do_step(1'b0, 3, 1'b1);
        // timeouts on each sub-transfer
        sl_present = 4'h6; sl_bit = 4'h2;
        do_step(1'b0, 0, 1'b0);
        do_step(1'b0, 1, 1'b0);
        do_step(1'b1, 2, 1'b0);
        // recovery after an abort clears the error
        do_step(1'b1, 3, 1'b0);

        // random
        for (int i = 0; i < 60; i++) begin
            sl_present = 4'($urandom);
            sl_bit = 4'($urandom);
            do_step(1'($urandom), ($urandom % 8 == 0) ? int'($urandom % 3) : 3,
                    ($urandom % 5) == 0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule